// File: doc/BRIEF.md
# Synchronized Peripheral Control Register

This block is the 32-bit control register of a peripheral. The register is written and read over a simple bus port. Bit 0 requests a self-clearing software reset. Bit 1 turns the peripheral on or off. Bits 31:2 hold configuration that is passed on to the peripheral.

The peripheral lives behind a synchronization boundary, which is modelled here as a fixed latency of `SYNC_LAT` clocks. A change to the enable bit reads back at once, but the peripheral-side enable state follows only after that latency. A busy flag covers the whole window. A software reset clears the register straight away and also takes `SYNC_LAT` clocks to complete. During that time every write is refused with a bus error, and reads return the reset pattern.

The configuration field is write-protected while the peripheral is on or switching state. Writes to it in that condition are dropped silently.

Top module: `ctrl_sync_reg`

## Requirements
- R1: While `rst` is high and after it is released, every output is zero.
- R2: A write with bit 0 set, accepted while no reset is running, starts a software reset. All other bits of that write are discarded. The register, the enable bit and the configuration are cleared. `rst_busy` is high for exactly `SYNC_LAT` cycles after the write edge. When it falls, `periph_en` is 0.
- R3: While `rst_busy` is high, `rd_data` reads 32'h0000_0001, meaning bit 0 is set and every other bit is zero.
- R4: A write made while `rst_busy` is high changes no state. `bus_err` is high for exactly the one cycle after that write edge, and is low otherwise.
- R5: A write with bit 0 clear never starts a reset.
- R6: Outside a reset, `rd_data` bit 1 shows the last accepted enable value from the cycle after the write. Bit 0 reads 0 and bits 31:2 show the configuration.
- R7: An accepted write whose bit 1 differs from the stored enable bit raises `en_busy` for `SYNC_LAT` cycles. This restarts any window already running. `periph_en` takes the stored value as `en_busy` falls. A write with an unchanged bit 1 does not raise `en_busy`.
- R8: Bits 31:2 of an accepted non-reset write are stored only when both the stored enable bit and `periph_en` are 0. Otherwise they are dropped without a bus error. `cfg_out` always equals the stored configuration.
- R9: A software reset cancels a pending enable change. `en_busy` is low from the cycle after the reset write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read value of the register |
| bus_err | output | 1 | Error response for a write refused during reset |
| en_busy | output | 1 | Enable change in progress |
| rst_busy | output | 1 | Software reset in progress |
| periph_en | output | 1 | Peripheral-side enable state |
| cfg_out | output | 30 | Configuration field to the peripheral |

## Verification
The bench builds the block with the default `SYNC_LAT` of 4. That latency is long enough to toggle the enable bit back in the middle of a running window. It also leaves room to issue a reset while an enable change is still pending, and to land several refused writes inside one reset window. A behavioural model tracks both windows as integer countdowns and is compared with every output on every clock. The run covers directed sequences and then a long pseudo-random stream of writes.

// File: rtl/ctrl_sync_reg_pkg.sv
package ctrl_sync_reg_pkg;
    localparam int WORD_W = 32;
    localparam int CFG_W  = WORD_W - 2;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic             en;
        logic             srst;
    } ctrl_word_t;

    localparam ctrl_word_t WORD_RESET = '0;

    function automatic ctrl_word_t read_view(input logic resetting,
                                             input logic en,
                                             input logic [CFG_W-1:0] cfg);
        ctrl_word_t w;
        if (resetting) begin
            w = WORD_RESET;
            w.srst = 1'b1;
        end else begin
            w.cfg  = cfg;
            w.en   = en;
            w.srst = 1'b0;
        end
        return w;
    endfunction
endpackage

// File: rtl/ctrl_lat_timer.sv
module ctrl_lat_timer #(
    parameter int SYNC_LAT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(SYNC_LAT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (start)
            cnt <= CW'(SYNC_LAT);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1)) && !start && !clr;
endmodule

// File: rtl/ctrl_cfg_bank.sv
module ctrl_cfg_bank #(
    parameter int CFG_W = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             we,
    input  logic [CFG_W-1:0] d,
    output logic [CFG_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= '0;
        else if (we)
            q <= d;
    end
endmodule

// File: rtl/ctrl_sync_reg.sv
module ctrl_sync_reg
    import ctrl_sync_reg_pkg::*;
#(
    parameter int SYNC_LAT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              bus_err,
    output logic              en_busy,
    output logic              rst_busy,
    output logic              periph_en,
    output logic [CFG_W-1:0]  cfg_out
);
    ctrl_word_t wdat;
    ctrl_word_t rview;
    logic       accept;
    logic       srst_req;
    logic       en_start;
    logic       cfg_we;
    logic       en_done;
    logic       rst_done;
    logic       en_q;

    assign wdat     = ctrl_word_t'(wr_data);
    assign accept   = wr_en && !rst_busy;
    assign srst_req = accept && wdat.srst;
    assign en_start = accept && !wdat.srst && (wdat.en != en_q);
    assign cfg_we   = accept && !wdat.srst && !en_q && !periph_en;

    ctrl_lat_timer #(.SYNC_LAT(SYNC_LAT)) u_rst_tmr (
        .clk(clk), .rst(rst), .clr(1'b0), .start(srst_req),
        .busy(rst_busy), .done(rst_done)
    );

    ctrl_lat_timer #(.SYNC_LAT(SYNC_LAT)) u_en_tmr (
        .clk(clk), .rst(rst), .clr(srst_req), .start(en_start),
        .busy(en_busy), .done(en_done)
    );

    ctrl_cfg_bank #(.CFG_W(CFG_W)) u_cfg (
        .clk(clk), .rst(rst), .clr(srst_req), .we(cfg_we),
        .d(wdat.cfg), .q(cfg_out)
    );

    always_ff @(posedge clk) begin
        if (rst || srst_req)
            en_q <= 1'b0;
        else if (en_start)
            en_q <= wdat.en;
    end

    always_ff @(posedge clk) begin
        if (rst || rst_done)
            periph_en <= 1'b0;
        else if (en_done)
            periph_en <= en_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_err <= 1'b0;
        else
            bus_err <= wr_en && rst_busy;
    end

    assign rview   = read_view(rst_busy, en_q, cfg_out);
    assign rd_data = WORD_W'(rview);
endmodule

// File: rtl/ctrl_sync_reg_chk.sv
module ctrl_sync_reg_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        bus_err,
    input logic        en_busy,
    input logic        rst_busy,
    input logic        periph_en,
    input logic [29:0] cfg_out
);
    // R4
    refused_write_err_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rst_busy) |=> bus_err);

    // R4
    err_only_when_refused_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && rst_busy) |=> !bus_err);

    // R3
    read_during_reset_chk: assert property (@(posedge clk) disable iff (rst)
        rst_busy |-> (rd_data == 32'h0000_0001));

    // R2
    reset_start_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rst_busy && wr_data[0]) |=> (rst_busy && cfg_out == '0));

    // R9
    reset_cancels_enable_chk: assert property (@(posedge clk) disable iff (rst)
        rst_busy |-> !en_busy);

    // R8
    cfg_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rst_busy && !wr_data[0] && (rd_data[1] || periph_en)) |=> $stable(cfg_out));

    // R7
    periph_follows_window_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(periph_en) |-> $past(en_busy || rst_busy));
endmodule

bind ctrl_sync_reg ctrl_sync_reg_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .bus_err(bus_err), .en_busy(en_busy),
    .rst_busy(rst_busy), .periph_en(periph_en), .cfg_out(cfg_out)
);

// File: tb/ctrl_sync_reg_tb.sv
module ctrl_sync_reg_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        bus_err, en_busy, rst_busy, periph_en;
    logic [29:0] cfg_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // behavioural model state
    int          m_rcnt = 0;
    int          m_ecnt = 0;
    bit          m_en = 0;
    bit          m_pen = 0;
    bit          m_err = 0;
    logic [29:0] m_cfg = '0;

    ctrl_sync_reg #(.SYNC_LAT(LAT)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .bus_err(bus_err), .en_busy(en_busy),
        .rst_busy(rst_busy), .periph_en(periph_en), .cfg_out(cfg_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    // model update at each edge
    always @(posedge clk) begin
        bit en_old, pen_old;
        en_old  = m_en;
        pen_old = m_pen;
        if (rst) begin
            m_rcnt = 0; m_ecnt = 0; m_en = 0; m_pen = 0; m_err = 0; m_cfg = '0;
        end else begin
            m_err = wr_en && (m_rcnt > 0);
            if (m_rcnt > 0) begin
                m_rcnt--;
                if (m_rcnt == 0) m_pen = 0;
            end else if (wr_en && wr_data[0]) begin
                m_rcnt = LAT; m_en = 0; m_cfg = '0; m_ecnt = 0;
            end else begin
                if (wr_en && !en_old && !pen_old) m_cfg = wr_data[31:2];
                if (wr_en && (wr_data[1] != en_old)) begin
                    m_en = wr_data[1];
                    m_ecnt = LAT;
                end else if (m_ecnt > 0) begin
                    m_ecnt--;
                    if (m_ecnt == 0) m_pen = en_old;
                end
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        logic [31:0] exp_rd;
        if (!rst && !finished) begin
            exp_rd = (m_rcnt > 0) ? 32'h1 : {m_cfg, m_en, 1'b0};
            check(rd_data == exp_rd, (m_rcnt > 0) ? "R3" : "R6", rd_data, exp_rd);
            check(rst_busy == (m_rcnt > 0), "R2", 32'(rst_busy), 32'(m_rcnt > 0));
            check(bus_err == m_err, "R4", 32'(bus_err), 32'(m_err));
            check(en_busy == (m_ecnt > 0), "R7", 32'(en_busy), 32'(m_ecnt > 0));
            check(periph_en == m_pen, "R7", 32'(periph_en), 32'(m_pen));
            check(cfg_out == m_cfg, "R8", 32'(cfg_out), 32'(m_cfg));
        end
    end

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] lcg = 32'h1234_5678;
        idle(3);
        #1 check({rd_data, bus_err, en_busy, rst_busy, periph_en, cfg_out} == '0,
                 "R1", rd_data, 32'h0);
        @(negedge clk); rst = 1'b0;
        idle(1);
        check(rd_data == 32'h0, "R1", rd_data, 32'h0);

        wr(32'hABCD_0000);                 // cfg accepted while disabled (R8)
        check(cfg_out == 30'(32'hABCD_0000 >> 2), "R8", 32'(cfg_out), 32'hABCD_0000 >> 2);
        wr(32'h0000_0000);                 // bit 0 clear (R5)
        check(!rst_busy, "R5", 32'(rst_busy), 32'h0);
        wr(32'h1234_0002);                 // enable, cfg accepted
        check(rd_data[1] == 1'b1, "R6", rd_data, 32'h1234_0002);
        idle(6);
        check(periph_en, "R7", 32'(periph_en), 32'h1);
        wr(32'hFFFF_0002);                 // locked cfg
        check(cfg_out == 30'(32'h1234_0000 >> 2) && !bus_err, "R8",
              32'(cfg_out), 32'h1234_0000 >> 2);
        wr(32'h0); idle(1); wr(32'h2);     // toggle back mid window
        idle(8);
        wr(32'hFFFF_FFFF);                 // reset, other bits dropped
        check(rd_data == 32'h1, "R3", rd_data, 32'h1);
        @(negedge clk); wr_en = 1'b1; wr_data = 32'h2;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
        check(bus_err, "R4", 32'(bus_err), 32'h1);
        idle(6);
        check(rd_data == 32'h0 && !periph_en, "R2", rd_data, 32'h0);
        wr(32'h2); wr(32'h1);              // reset aborts pending enable
        check(!en_busy, "R9", 32'(en_busy), 32'h0);
        idle(6);

        for (int i = 0; i < 3000; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            @(negedge clk);
            wr_en = lcg[31] | lcg[30];
            wr_data = {lcg[23:0], lcg[29:24], lcg[17], (lcg[28:25] == 4'h0)};
        end
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
        idle(10);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule